// File: doc/BRIEF.md
# SDRAM Clock-Enable Power State Machine

This block follows the clock-enable pin of a synchronous DRAM and decides, for every rising clock edge, what that pin means for the device. It keeps the clock-enable level seen at the previous edge and compares it with the level at the current edge. It combines that pair with the present power state, an all-banks-idle flag from the bank logic, and the command strobes. From these it moves the device between normal running, clock suspend, power-down and self-refresh.

For each cycle it reports a numbered action code: enter, hold or leave a mode, wait for the row cycle after self-refresh, or flag the cycle as illegal. It also gives the command decoder a command-enable gate. While suspend is in force it raises a hold signal, which freezes burst counters, the read latency pipeline and the output data elsewhere in the device. The asynchronous wake-up from self-refresh is modelled as a synchronous wait of a parameterised number of row-cycle clocks.

The action code and the command-enable gate are combinational results for the current edge. They are valid once the inputs have settled before that edge. The power state is registered and changes at the edge.

Top module: `cke_power_fsm`

## Requirements
- R1: Reset (rst_n low, active low, synchronous to clk) gives power state 0 (running), clk_hold low, and a remembered previous clock-enable of high. With cke high and a no-operation command after reset, action is 0 (none) and cmd_en is high.
- R2: cmd_en is high only in the running state when the previous-edge clock-enable was high and the action is 0 (none) or 1 (suspend begin). cmd_en is low in every other state and on cycles flagged illegal or consumed as a mode entry.
- R3: Assume running, banks_idle low, and cke going from high (previous edge) to low (current edge). Action is 1 (suspend begin) whatever the command, and the state becomes 1 (suspend) at the edge.
- R4: In suspend, cke low gives action 2 (suspend hold), and cke high gives action 3 (suspend end), after which the state returns to 0 (running). clk_hold is high in every cycle the state is suspend, including the end cycle, and low again in the next cycle.
- R5: Assume running, banks_idle high, and cke going from high to low. A deselect command (cs_n high) or a no-operation command (cs_n low, ras_n high, cas_n high, we_n high) gives action 4 (power-down enter), and the state becomes 2 (power-down).
- R6: In power-down, cke low gives action 5 (power-down hold) with cmd_en low, so any command is ignored. cke high gives action 6 (power-down exit), and the state becomes 0 (running).
- R7: Assume running, banks_idle high, and cke going from high to low. An auto-refresh command (cs_n low, ras_n low, cas_n low, we_n high) gives action 7 (self-refresh enter), and the state becomes 3 (self-refresh). With banks_idle low the same pattern starts suspend instead and never reaches self-refresh.
- R8: In self-refresh with cke low, action is 8 (self-refresh hold), and the state stays 3.
- R9: In self-refresh, cke going from low to high gives action 9 (self-refresh exit) with a deselect or no-operation command. The state becomes 4 (exit wait) and stays there for exactly TRC_CYCLES cycles, each reporting action 10 (exit wait) with cmd_en low. It then returns to 0 (running).
- R10: Action 11 (illegal) is reported with cmd_en low in three cases: any command other than deselect or no-operation on a self-refresh exit cycle, on an exit-wait cycle, or on an idle high-to-low clock-enable cycle other than auto-refresh. An illegal idle drop leaves the state at 0. An illegal self-refresh exit still proceeds into the exit wait.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Device clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cke | input | 1 | Clock-enable level at this edge |
| cs_n | input | 1 | Chip select, low selects |
| ras_n | input | 1 | Row strobe |
| cas_n | input | 1 | Column strobe |
| we_n | input | 1 | Write strobe |
| banks_idle | input | 1 | High when every bank is precharged |
| pstate | output | 3 | Power state: 0 running, 1 suspend, 2 power-down, 3 self-refresh, 4 exit wait |
| action | output | 4 | Action code for this edge (see requirements; 12 marks an invalid previous-edge level) |
| cmd_en | output | 1 | Command decoder may execute the command at this edge |
| clk_hold | output | 1 | Freeze burst counters, latency pipeline and output data |

## Verification
The bench builds the block with TRC_CYCLES set to 4. This keeps the exit wait short enough to walk cycle by cycle. It also leaves room for a wait cycle in the middle that carries a row command, and a following cycle that must still be counted. With that value the bench can confirm the exact return to running after the fourth wait cycle. It also drives both the legal and the illegal forms of every clock-enable transition with banks_idle at each level.

// File: rtl/cke_pwr_pkg.sv
package cke_pwr_pkg;

  typedef enum logic [2:0] {
    ST_RUN  = 3'd0,
    ST_SUSP = 3'd1,
    ST_PDN  = 3'd2,
    ST_SREF = 3'd3,
    ST_SRX  = 3'd4
  } pwr_state_t;

  typedef enum logic [3:0] {
    AC_NONE       = 4'd0,
    AC_SUSP_BEGIN = 4'd1,
    AC_SUSP_HOLD  = 4'd2,
    AC_SUSP_END   = 4'd3,
    AC_PD_ENTER   = 4'd4,
    AC_PD_HOLD    = 4'd5,
    AC_PD_EXIT    = 4'd6,
    AC_SR_ENTER   = 4'd7,
    AC_SR_HOLD    = 4'd8,
    AC_SR_EXIT    = 4'd9,
    AC_SR_WAIT    = 4'd10,
    AC_ILLEGAL    = 4'd11,
    AC_INVALID    = 4'd12
  } pwr_act_t;

  typedef struct packed {
    logic quiet;
    logic aref;
  } cmd_class_t;

endpackage

// File: rtl/cke_cmd_decode.sv
module cke_cmd_decode
  import cke_pwr_pkg::*;
(
  input  logic       cs_n,
  input  logic       ras_n,
  input  logic       cas_n,
  input  logic       we_n,
  output cmd_class_t cls
);

  logic desel;
  logic nop;

  always_comb begin
    desel     = cs_n;
    nop       = !cs_n && ras_n && cas_n && we_n;
    cls.quiet = desel || nop;
    cls.aref  = !cs_n && !ras_n && !cas_n && we_n;
  end

endmodule

// File: rtl/cke_exit_timer.sv
module cke_exit_timer #(
  parameter int TRC_CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic run,
  output logic last
);

  localparam int CNT_W = $clog2(TRC_CYCLES + 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= CNT_W'(TRC_CYCLES);
    end else if (run && cnt_q != '0) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assign last = (cnt_q == CNT_W'(1)) || (cnt_q == '0);

  assert_cnt_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(TRC_CYCLES));

  assert_cnt_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !load && cnt_q > CNT_W'(1)) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

endmodule

// File: rtl/cke_state_ctrl.sv
module cke_state_ctrl
  import cke_pwr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cke,
  input  logic       cke_prev,
  input  cmd_class_t cls,
  input  logic       banks_idle,
  input  logic       tmr_last,
  output pwr_state_t state_o,
  output pwr_act_t   action_o,
  output logic       cmd_en_o,
  output logic       tmr_load_o
);

  pwr_state_t state_q;
  pwr_state_t state_d;
  pwr_act_t   act;
  logic       load;

  always_comb begin
    state_d = state_q;
    act     = AC_NONE;
    load    = 1'b0;
    unique case (state_q)
      ST_RUN: begin
        if (cke_prev && !cke) begin
          if (banks_idle) begin
            if (cls.aref) begin
              act     = AC_SR_ENTER;
              state_d = ST_SREF;
            end else if (cls.quiet) begin
              act     = AC_PD_ENTER;
              state_d = ST_PDN;
            end else begin
              act = AC_ILLEGAL;
            end
          end else begin
            act     = AC_SUSP_BEGIN;
            state_d = ST_SUSP;
          end
        end
      end
      ST_SUSP: begin
        if (cke) begin
          act     = AC_SUSP_END;
          state_d = ST_RUN;
        end else begin
          act = AC_SUSP_HOLD;
        end
      end
      ST_PDN: begin
        if (cke_prev) begin
          act = AC_INVALID;
          if (cke) state_d = ST_RUN;
        end else if (cke) begin
          act     = AC_PD_EXIT;
          state_d = ST_RUN;
        end else begin
          act = AC_PD_HOLD;
        end
      end
      ST_SREF: begin
        if (cke_prev) begin
          act = AC_INVALID;
        end else if (cke) begin
          act     = cls.quiet ? AC_SR_EXIT : AC_ILLEGAL;
          state_d = ST_SRX;
          load    = 1'b1;
        end else begin
          act = AC_SR_HOLD;
        end
      end
      ST_SRX: begin
        act = cls.quiet ? AC_SR_WAIT : AC_ILLEGAL;
        if (tmr_last) state_d = ST_RUN;
      end
      default: begin
        state_d = ST_RUN;
        act     = AC_INVALID;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= ST_RUN;
    else        state_q <= state_d;
  end

  assign state_o    = state_q;
  assign action_o   = act;
  assign tmr_load_o = load;
  assign cmd_en_o   = (state_q == ST_RUN) && cke_prev &&
                      (act == AC_NONE || act == AC_SUSP_BEGIN);

  assert_gate_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_RUN) |-> !cmd_en_o);

  assert_busy_suspend_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN && !banks_idle && cke_prev && !cke) |=> state_q == ST_SUSP);

  assert_pdn_exit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_PDN && cke) |=> state_q == ST_RUN);

  assert_sref_guard_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN && !banks_idle) |=> state_q != ST_SREF);

  assert_sref_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SREF && !cke) |=> state_q == ST_SREF);

  assert_srx_stay_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SRX && !tmr_last) |=> state_q == ST_SRX);

  assert_srx_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SRX && tmr_last) |=> state_q == ST_RUN);

  assert_sref_wake_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SREF && !cke_prev && cke) |=> state_q == ST_SRX);

endmodule

// File: rtl/cke_power_fsm.sv
module cke_power_fsm
  import cke_pwr_pkg::*;
#(
  parameter int TRC_CYCLES = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cke,
  input  logic       cs_n,
  input  logic       ras_n,
  input  logic       cas_n,
  input  logic       we_n,
  input  logic       banks_idle,
  output logic [2:0] pstate,
  output logic [3:0] action,
  output logic       cmd_en,
  output logic       clk_hold
);

  logic       cke_prev_q;
  cmd_class_t cls;
  pwr_state_t st;
  pwr_act_t   act;
  logic       tmr_load;
  logic       tmr_last;

  always_ff @(posedge clk) begin
    if (!rst_n) cke_prev_q <= 1'b1;
    else        cke_prev_q <= cke;
  end

  cke_cmd_decode u_dec (
    .cs_n  (cs_n),
    .ras_n (ras_n),
    .cas_n (cas_n),
    .we_n  (we_n),
    .cls   (cls)
  );

  cke_exit_timer #(.TRC_CYCLES(TRC_CYCLES)) u_tmr (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (tmr_load),
    .run   (st == ST_SRX),
    .last  (tmr_last)
  );

  cke_state_ctrl u_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .cke        (cke),
    .cke_prev   (cke_prev_q),
    .cls        (cls),
    .banks_idle (banks_idle),
    .tmr_last   (tmr_last),
    .state_o    (st),
    .action_o   (act),
    .cmd_en_o   (cmd_en),
    .tmr_load_o (tmr_load)
  );

  assign pstate   = st;
  assign action   = act;
  assign clk_hold = (st == ST_SUSP);

  assert_hold_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_hold && cke) |=> !clk_hold);

endmodule

// File: tb/cke_power_fsm_test.sv
module cke_power_fsm_test;

  localparam logic [3:0] C_NOP = 4'b0111;
  localparam logic [3:0] C_DES = 4'b1111;
  localparam logic [3:0] C_REF = 4'b0001;
  localparam logic [3:0] C_ACT = 4'b0011;
  localparam logic [3:0] C_RD  = 4'b0101;
  localparam logic [3:0] C_WR  = 4'b0100;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cke = 1'b1;
  logic cs_n = 1'b0, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic banks_idle = 1'b1;
  logic [2:0] pstate;
  logic [3:0] action;
  logic cmd_en, clk_hold;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  cke_power_fsm #(.TRC_CYCLES(4)) uut (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .banks_idle(banks_idle),
    .pstate(pstate), .action(action), .cmd_en(cmd_en), .clk_hold(clk_hold)
  );

  task automatic check(input string req, input string what, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, got, exp);
    end
  endtask

  task automatic step(input logic k, input logic [3:0] c);
    @(negedge clk);
    cke = k;
    {cs_n, ras_n, cas_n, we_n} = c;
    #2;
  endtask

  task automatic see(input string req, input int st, input int ac, input int en);
    check(req, "pstate", int'(pstate), st);
    check(req, "action", int'(action), ac);
    check(req, "cmd_en", int'(cmd_en), en);
  endtask

  task automatic t_reset;
    #2;
    check("R1", "pstate in reset", int'(pstate), 0);
    check("R1", "clk_hold in reset", int'(clk_hold), 0);
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #2;
    see("R1", 0, 0, 1);
  endtask

  task automatic t_suspend;
    banks_idle = 1'b0;
    step(1'b1, C_NOP); see("R2", 0, 0, 1);
    step(1'b0, C_RD);  see("R3", 0, 1, 1);
    step(1'b0, C_NOP); see("R4", 1, 2, 0);
    check("R4", "clk_hold held", int'(clk_hold), 1);
    step(1'b0, C_ACT); see("R4", 1, 2, 0);
    step(1'b1, C_NOP); see("R4", 1, 3, 0);
    check("R4", "clk_hold end cycle", int'(clk_hold), 1);
    step(1'b1, C_NOP); see("R4", 0, 0, 1);
    check("R4", "clk_hold released", int'(clk_hold), 0);
  endtask

  task automatic t_powerdown;
    banks_idle = 1'b1;
    step(1'b1, C_NOP); see("R2", 0, 0, 1);
    step(1'b0, C_DES); see("R5", 0, 4, 0);
    step(1'b0, C_ACT); see("R6", 2, 5, 0);
    step(1'b0, C_NOP); see("R6", 2, 5, 0);
    step(1'b1, C_NOP); see("R6", 2, 6, 0);
    step(1'b1, C_NOP); see("R6", 0, 0, 1);
    step(1'b0, C_NOP); see("R5", 0, 4, 0);
    step(1'b1, C_NOP); see("R6", 2, 6, 0);
    step(1'b1, C_NOP); see("R6", 0, 0, 1);
  endtask

  task automatic t_selfref;
    banks_idle = 1'b1;
    step(1'b1, C_NOP); see("R2", 0, 0, 1);
    step(1'b0, C_REF); see("R7", 0, 7, 0);
    step(1'b0, C_NOP); see("R8", 3, 8, 0);
    step(1'b0, C_RD);  see("R8", 3, 8, 0);
    step(1'b1, C_NOP); see("R9", 3, 9, 0);
    step(1'b1, C_NOP); see("R9", 4, 10, 0);
    step(1'b1, C_ACT); see("R10", 4, 11, 0);
    step(1'b1, C_DES); see("R9", 4, 10, 0);
    step(1'b1, C_NOP); see("R9", 4, 10, 0);
    step(1'b1, C_NOP); see("R9", 0, 0, 1);
  endtask

  task automatic t_bad_wake;
    banks_idle = 1'b1;
    step(1'b1, C_NOP); see("R2", 0, 0, 1);
    step(1'b0, C_REF); see("R7", 0, 7, 0);
    step(1'b0, C_NOP); see("R8", 3, 8, 0);
    step(1'b1, C_RD);  see("R10", 3, 11, 0);
    for (int i = 0; i < 4; i++) begin
      step(1'b1, C_NOP); see("R10", 4, 10, 0);
    end
    step(1'b1, C_NOP); see("R10", 0, 0, 1);
  endtask

  task automatic t_bad_drop;
    banks_idle = 1'b1;
    step(1'b1, C_NOP); see("R2", 0, 0, 1);
    step(1'b0, C_WR);  see("R10", 0, 11, 0);
    step(1'b0, C_NOP); see("R10", 0, 0, 0);
    step(1'b1, C_NOP); see("R2", 0, 0, 0);
    step(1'b1, C_NOP); see("R2", 0, 0, 1);
  endtask

  task automatic t_busy_refresh;
    banks_idle = 1'b0;
    step(1'b1, C_NOP); see("R2", 0, 0, 1);
    step(1'b0, C_REF); see("R7", 0, 1, 1);
    step(1'b0, C_NOP); see("R7", 1, 2, 0);
    step(1'b1, C_NOP); see("R4", 1, 3, 0);
    step(1'b1, C_NOP); see("R4", 0, 0, 1);
  endtask

  initial begin
    t_reset();
    t_suspend();
    t_powerdown();
    t_selfref();
    t_bad_wake();
    t_bad_drop();
    t_busy_refresh();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule